// File: doc/BRIEF.md
# Static Slot Null-Frame Decision and Buffer State Update

This block sits in the transmit path of a time-triggered bus controller. At every static slot boundary it searches a small array of transmit message buffers for the number of the slot that follows. It decides whether that slot belongs to this node on channel A. It also decides whether the slot will carry a real data frame or a null frame, and it moves the buffers picked for a null frame through their state sequence.

The search runs in the slot before the one it concerns. The result is held and acted on at the next slot start, when a one-cycle pulse announces either a null frame or a data frame. A data frame also carries the index of the buffer to send. Buffers picked for a null frame go to a selected state at the search, to a transmitting state at the next slot start, and back to rest one slot later. Host locking is tracked between slot starts.

Top module: `ssnf_slot_null`

## Requirements
- R1: After reset every buffer state reads Idle (code 0 in its 3-bit field of `bufState`, buffer i at bits 3i+2..3i), and `nullTx` and `dataTx` are 0.
- R2: A slot is owned only if some buffer has `chA`=1 and a frame ID equal to `nextSlot`. For an unowned slot, neither pulse is raised at the following slot start and no buffer state changes.
- R3: If an owned slot has no eligible buffer, `nullTx` is 1 for exactly one cycle, in the cycle right after the slot start that follows the search. A buffer whose commit was cleared counts as not eligible.
- R4: A committed buffer that the host holds locked counts as not eligible, so it leads to a null frame.
- R5: A committed, unlocked buffer whose cycle filter is enabled (`bufFiltEn`=1) with `bufCycMatch`=0 counts as not eligible.
- R6: A matching buffer is eligible when it is committed, unlocked and passes its filter. If any matching buffer is eligible, `dataTx` pulses for one cycle in place of `nullTx`, and `dataIdx` gives the lowest eligible index. In that case no buffer state changes.
- R7: At a search that yields a null frame, a non-eligible matching buffer moves from Idle to null-selected (code 2), or from host-locked (code 1) to locked-and-selected (code 3).
- R8: The transition in R7 applies to at most two buffers per search, and those are the two lowest indices.
- R9: At the next slot start, states 2 and 3 move to null-transmitting (code 4). At the slot start after that, state 4 returns to Idle, or to host-locked if `bufLock` is 1.
- R10: Between slot starts, `bufLock` moves Idle to host-locked and back, and null-selected to locked-and-selected and back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| slotStart | input | 1 | One-cycle pulse at each static slot boundary |
| nextSlot | input | FID_W | Slot number to search (current slot + 1) |
| bufFid | input | NUM_BUF*FID_W | Frame ID of each buffer, buffer i at slice i |
| bufChA | input | NUM_BUF | Channel A enable per buffer |
| bufCommit | input | NUM_BUF | Commit flag per buffer |
| bufLock | input | NUM_BUF | Host lock flag per buffer |
| bufFiltEn | input | NUM_BUF | Cycle filter enable per buffer |
| bufCycMatch | input | NUM_BUF | Cycle filter matches current cycle |
| nullTx | output | 1 | One-cycle null frame transmit pulse |
| dataTx | output | 1 | One-cycle data frame transmit pulse |
| dataIdx | output | IDX_W | Buffer index for the data frame |
| bufState | output | NUM_BUF*3 | State code of each buffer |

## Verification
The hardest cases to reach are the composite lock states. To get there, the host lock must change while a buffer waits between its selection and its transmit slot, and a lock must still be held when the transmitting state ends. The stimulus reaches them with directed slot pulses. It holds `bufLock` across a selection to enter code 3, and it toggles the lock in the idle cycles between two slot starts to move between codes 2 and 3. It also keeps the lock raised through the slot start that ends state 4, so that the return goes to code 1 rather than Idle.

// File: rtl/ssnf_pkg.sv
package ssnf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_HLOCK      = 3'd1,
    ST_NSEL       = 3'd2,
    ST_HLOCK_NSEL = 3'd3,
    ST_NTX        = 3'd4
  } bufState_e;

  typedef struct packed {
    logic advance;   // slot boundary: step selected/transmitting states
    logic applySa;   // search yielded a null frame: select picked buffers
  } slotStrobe_t;
endpackage

// File: rtl/ssnf_match_dp.sv
module ssnf_match_dp
  import ssnf_pkg::*;
#(
  parameter int NUM_BUF   = 4,
  parameter int FID_W     = 11,
  parameter int IDX_W     = 2,
  parameter int SEL_LIMIT = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  slotStrobe_t              strobe,
  input  logic [FID_W-1:0]         nextSlot,
  input  logic [NUM_BUF*FID_W-1:0] bufFid,
  input  logic [NUM_BUF-1:0]       bufChA,
  input  logic [NUM_BUF-1:0]       bufCommit,
  input  logic [NUM_BUF-1:0]       bufLock,
  input  logic [NUM_BUF-1:0]       bufFiltEn,
  input  logic [NUM_BUF-1:0]       bufCycMatch,
  output logic                     owned,
  output logic                     anyElig,
  output logic [IDX_W-1:0]         firstIdx,
  output logic [NUM_BUF*3-1:0]     bufStateFlat
);
  localparam int CNT_W = $clog2(NUM_BUF + 1) + 1;

  logic [NUM_BUF-1:0] hit, elig, nullCond, pick;

  for (genvar g = 0; g < NUM_BUF; g++) begin : gBuf
    bufState_e cur, nxt;
    logic restOk;

    assign hit[g]  = bufChA[g] && (bufFid[g*FID_W +: FID_W] == nextSlot);
    assign elig[g] = hit[g] && bufCommit[g] && !bufLock[g] &&
                     (!bufFiltEn[g] || bufCycMatch[g]);
    assign restOk  = (cur == ST_IDLE) || (cur == ST_HLOCK);
    assign nullCond[g] = hit[g] && !elig[g] && restOk;

    always_comb begin
      nxt = cur;
      if (strobe.advance) begin
        case (cur)
          ST_NSEL, ST_HLOCK_NSEL: nxt = ST_NTX;
          ST_NTX:   nxt = bufLock[g] ? ST_HLOCK : ST_IDLE;
          ST_IDLE:  nxt = (strobe.applySa && pick[g]) ? ST_NSEL :
                          (bufLock[g] ? ST_HLOCK : ST_IDLE);
          ST_HLOCK: nxt = (strobe.applySa && pick[g]) ? ST_HLOCK_NSEL :
                          (bufLock[g] ? ST_HLOCK : ST_IDLE);
          default:  nxt = ST_IDLE;
        endcase
      end else begin
        case (cur)
          ST_IDLE, ST_HLOCK:      nxt = bufLock[g] ? ST_HLOCK : ST_IDLE;
          ST_NSEL, ST_HLOCK_NSEL: nxt = bufLock[g] ? ST_HLOCK_NSEL : ST_NSEL;
          ST_NTX:                 nxt = ST_NTX;
          default:                nxt = ST_IDLE;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) cur <= ST_IDLE;
      else       cur <= nxt;
    end

    assign bufStateFlat[g*3 +: 3] = cur;
  end

  // Pick the lowest-index buffers meeting a null condition, up to SEL_LIMIT.
  always_comb begin
    logic [CNT_W-1:0] cnt;
    cnt  = '0;
    pick = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (nullCond[i] && (cnt < CNT_W'(SEL_LIMIT))) begin
        pick[i] = 1'b1;
        cnt     = cnt + 1'b1;
      end
    end
  end

  // Lowest eligible index wins the data frame.
  always_comb begin
    firstIdx = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (elig[i]) firstIdx = IDX_W'(i);
    end
  end

  assign owned   = |hit;
  assign anyElig = |elig;
endmodule

// File: rtl/ssnf_ctrl.sv
module ssnf_ctrl
  import ssnf_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slotStart,
  input  logic             owned,
  input  logic             anyElig,
  input  logic [IDX_W-1:0] firstIdx,
  output slotStrobe_t      strobe,
  output logic             nullTx,
  output logic             dataTx,
  output logic [IDX_W-1:0] dataIdx
);
  logic             pendOwned, pendData;
  logic [IDX_W-1:0] pendIdx;

  assign strobe.advance = slotStart;
  assign strobe.applySa = slotStart && owned && !anyElig;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendOwned <= 1'b0;
      pendData  <= 1'b0;
      pendIdx   <= '0;
      nullTx    <= 1'b0;
      dataTx    <= 1'b0;
      dataIdx   <= '0;
    end else begin
      nullTx <= slotStart && pendOwned && !pendData;
      dataTx <= slotStart && pendOwned && pendData;
      if (slotStart) begin
        dataIdx   <= pendIdx;
        pendOwned <= owned;
        pendData  <= anyElig;
        pendIdx   <= firstIdx;
      end
    end
  end
endmodule

// File: rtl/ssnf_slot_null.sv
module ssnf_slot_null
  import ssnf_pkg::*;
#(
  parameter int NUM_BUF = 4,
  parameter int FID_W   = 11,
  localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     slotStart,
  input  logic [FID_W-1:0]         nextSlot,
  input  logic [NUM_BUF*FID_W-1:0] bufFid,
  input  logic [NUM_BUF-1:0]       bufChA,
  input  logic [NUM_BUF-1:0]       bufCommit,
  input  logic [NUM_BUF-1:0]       bufLock,
  input  logic [NUM_BUF-1:0]       bufFiltEn,
  input  logic [NUM_BUF-1:0]       bufCycMatch,
  output logic                     nullTx,
  output logic                     dataTx,
  output logic [IDX_W-1:0]         dataIdx,
  output logic [NUM_BUF*3-1:0]     bufState
);
  slotStrobe_t      strobe;
  logic             owned, anyElig;
  logic [IDX_W-1:0] firstIdx;

  ssnf_ctrl #(.IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .slotStart(slotStart),
    .owned(owned), .anyElig(anyElig), .firstIdx(firstIdx),
    .strobe(strobe), .nullTx(nullTx), .dataTx(dataTx), .dataIdx(dataIdx)
  );

  ssnf_match_dp #(.NUM_BUF(NUM_BUF), .FID_W(FID_W), .IDX_W(IDX_W), .SEL_LIMIT(2)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .nextSlot(nextSlot),
    .bufFid(bufFid), .bufChA(bufChA), .bufCommit(bufCommit), .bufLock(bufLock),
    .bufFiltEn(bufFiltEn), .bufCycMatch(bufCycMatch),
    .owned(owned), .anyElig(anyElig), .firstIdx(firstIdx), .bufStateFlat(bufState)
  );
endmodule

// File: rtl/ssnf_checker.sv
module ssnf_checker #(
  parameter int NUM_BUF = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 slotStart,
  input logic                 nullTx,
  input logic                 dataTx,
  input logic [NUM_BUF*3-1:0] bufState
);
  logic                 prevSlot, prevValid;
  logic [NUM_BUF*3-1:0] prevState;
  int                   enterCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSlot  <= 1'b0;
      prevValid <= 1'b0;
      prevState <= '0;
    end else begin
      prevSlot  <= slotStart;
      prevValid <= 1'b1;
      prevState <= bufState;
    end
  end

  always_comb begin
    enterCnt = 0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if ((prevState[i*3 +: 3] <= 3'd1) &&
          (bufState[i*3 +: 3] == 3'd2 || bufState[i*3 +: 3] == 3'd3))
        enterCnt = enterCnt + 1;
    end
  end

  a_r6_one_kind: assert property (@(posedge clk) disable iff (!rstN)
    !(nullTx && dataTx));

  a_r3_after_slot: assert property (@(posedge clk) disable iff (!rstN)
    (nullTx || dataTx) |-> prevSlot);

  a_r8_two_max: assert property (@(posedge clk) disable iff (!rstN)
    prevValid |-> (enterCnt <= 2));

  for (genvar g = 0; g < NUM_BUF; g++) begin : gChk
    a_r9_ntx_exit: assert property (@(posedge clk) disable iff (!rstN)
      (prevValid && prevState[g*3 +: 3] == 3'd4 && bufState[g*3 +: 3] != 3'd4) |-> prevSlot);

    a_r7_sel_on_slot: assert property (@(posedge clk) disable iff (!rstN)
      (prevValid && prevState[g*3 +: 3] <= 3'd1 &&
       (bufState[g*3 +: 3] == 3'd2 || bufState[g*3 +: 3] == 3'd3)) |-> prevSlot);
  end
endmodule

bind ssnf_slot_null ssnf_checker #(.NUM_BUF(NUM_BUF)) chk_i (
  .clk(clk), .rstN(rstN), .slotStart(slotStart),
  .nullTx(nullTx), .dataTx(dataTx), .bufState(bufState)
);

// File: tb/ssnf_slot_null_tb_top.sv
module ssnf_slot_null_tb_top;
  localparam int NB = 4;
  localparam int FW = 11;

  logic          clk = 1'b0;
  logic          rstN;
  logic          slotStart;
  logic [FW-1:0] nextSlot;
  logic [NB*FW-1:0] bufFid;
  logic [NB-1:0] bufChA, bufCommit, bufLock, bufFiltEn, bufCycMatch;
  logic          nullTx, dataTx;
  logic [1:0]    dataIdx;
  logic [NB*3-1:0] bufState;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  ssnf_slot_null #(.NUM_BUF(NB), .FID_W(FW)) dut_i (
    .clk(clk), .rstN(rstN), .slotStart(slotStart), .nextSlot(nextSlot),
    .bufFid(bufFid), .bufChA(bufChA), .bufCommit(bufCommit), .bufLock(bufLock),
    .bufFiltEn(bufFiltEn), .bufCycMatch(bufCycMatch),
    .nullTx(nullTx), .dataTx(dataTx), .dataIdx(dataIdx), .bufState(bufState)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected<20000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int st(int i);
    return int'(bufState[i*3 +: 3]);
  endfunction

  task automatic clearCfg();
    bufFid = '0; bufChA = '0; bufCommit = '0; bufLock = '0;
    bufFiltEn = '0; bufCycMatch = '0;
  endtask

  task automatic setBuf(int i, int fid, bit ch, bit cmt, bit lck, bit fen, bit fm);
    bufFid[i*FW +: FW] = FW'(fid);
    bufChA[i] = ch; bufCommit[i] = cmt; bufLock[i] = lck;
    bufFiltEn[i] = fen; bufCycMatch[i] = fm;
  endtask

  // Pulse slotStart for one clock; returns at the negedge after the edge.
  task automatic slot(int nxt);
    nextSlot  = FW'(nxt);
    slotStart = 1'b1;
    @(negedge clk);
    slotStart = 1'b0;
  endtask

  task automatic tReset();
    for (int i = 0; i < NB; i++) chk("R1 state", st(i), 0);
    chk("R1 nullTx", int'(nullTx), 0);
    chk("R1 dataTx", int'(dataTx), 0);
  endtask

  task automatic tUnowned();
    clearCfg();
    setBuf(0, 5, 0, 0, 0, 0, 0);   // ID matches but channel A off
    setBuf(1, 6, 1, 0, 0, 0, 0);
    slot(5);
    for (int i = 0; i < NB; i++) chk("R2 state unchanged", st(i), 0);
    slot(9);
    chk("R2 no nullTx", int'(nullTx), 0);
    chk("R2 no dataTx", int'(dataTx), 0);
  endtask

  task automatic tNull();
    clearCfg();
    setBuf(1, 10, 1, 0, 0, 0, 0);  // uncommitted (aborted) buffer
    slot(10);
    chk("R7 idle to selected", st(1), 2);
    chk("R3 no pulse early", int'(nullTx), 0);
    slot(20);
    chk("R3 nullTx", int'(nullTx), 1);
    chk("R9 to transmitting", st(1), 4);
    @(negedge clk);
    chk("R3 one cycle", int'(nullTx), 0);
    chk("R9 hold transmitting", st(1), 4);
    slot(21);
    chk("R9 back to idle", st(1), 0);
    chk("R3 no repeat", int'(nullTx), 0);
  endtask

  task automatic tData();
    clearCfg();
    setBuf(0, 30, 1, 1, 0, 0, 0);
    setBuf(2, 30, 1, 1, 0, 0, 0);
    slot(30);
    slot(31);
    chk("R6 dataTx", int'(dataTx), 1);
    chk("R6 dataIdx lowest", int'(dataIdx), 0);
    chk("R6 no nullTx", int'(nullTx), 0);
    setBuf(0, 30, 1, 1, 0, 1, 0);  // filter blocks buffer 0
    slot(30);
    chk("R6 state kept", st(0), 0);
    slot(31);
    chk("R6 dataIdx skips filtered", int'(dataIdx), 2);
    chk("R6 dataTx again", int'(dataTx), 1);
    @(negedge clk);
    chk("R6 one cycle", int'(dataTx), 0);
    slot(31);
  endtask

  task automatic tFilter();
    clearCfg();
    setBuf(3, 40, 1, 1, 0, 1, 0);
    slot(40);
    chk("R5 selected", st(3), 2);
    slot(41);
    chk("R5 nullTx", int'(nullTx), 1);
    chk("R5 dataTx off", int'(dataTx), 0);
    slot(41);
    chk("R5 idle", st(3), 0);
  endtask

  task automatic tLock();
    clearCfg();
    setBuf(2, 50, 1, 1, 1, 0, 0);
    @(negedge clk);
    chk("R10 idle to hlock", st(2), 1);
    slot(50);
    chk("R7 hlock to hlock-sel", st(2), 3);
    slot(51);
    chk("R4 nullTx", int'(nullTx), 1);
    chk("R9 hlock-sel to transmitting", st(2), 4);
    slot(51);
    chk("R9 back to hlock", st(2), 1);
    bufLock[2] = 1'b0;
    @(negedge clk);
    chk("R10 hlock to idle", st(2), 0);
    bufCommit[2] = 1'b0;
    slot(50);
    chk("R7 selected", st(2), 2);
    bufLock[2] = 1'b1;
    @(negedge clk);
    chk("R10 sel to hlock-sel", st(2), 3);
    bufLock[2] = 1'b0;
    @(negedge clk);
    chk("R10 hlock-sel to sel", st(2), 2);
    slot(51);
    chk("R9 transmitting", st(2), 4);
    slot(51);
    chk("R9 idle", st(2), 0);
  endtask

  task automatic tTwo();
    clearCfg();
    for (int i = 0; i < NB; i++) setBuf(i, 60, 1, 0, 0, 0, 0);
    slot(60);
    chk("R8 buf0 sel", st(0), 2);
    chk("R8 buf1 sel", st(1), 2);
    chk("R8 buf2 not sel", st(2), 0);
    chk("R8 buf3 not sel", st(3), 0);
    slot(61);
    chk("R8 nullTx", int'(nullTx), 1);
    chk("R8 buf0 tx", st(0), 4);
    chk("R8 buf2 idle", st(2), 0);
    slot(61);
    chk("R8 buf1 idle", st(1), 0);
  endtask

  initial begin
    rstN = 1'b0; slotStart = 1'b0; nextSlot = '0;
    clearCfg();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tUnowned();
    tNull();
    tData();
    tFilter();
    tLock();
    tTwo();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule